// File: doc/BRIEF.md
# Weighted Circular Phase Correlator

This block estimates where the second boundary of a pulse-coded time signal sits within its local one-second period. Each sample strobe carries one demodulated bit, where 1 means carrier off. The bit is added into the counter of the current phase bin, and the bin pointer then steps around a ring of one hundred bins that spans one second. Over many seconds the bins build a histogram of where in the second the carrier tends to drop.

A pulse on `eval_go` starts a sequential scan. The scan slides a three-part kernel around the ring at one bin per clock. Each part is ten bins wide, and the parts are weighted 59, 34 and 8, the weights following how often each tenth of a second is carrier off. The running score moves from one phase to the next by adding weight differences at the part boundaries rather than by summing afresh. After the scan, the same kernel is applied once more, two part-widths past the winning phase, to give a noise figure. A one-cycle `done` pulse marks the new results. They stay on the outputs until the next evaluation.

Top module: `sec_phase_corr`

## Requirements
- R1: After reset every bin counts zero, the bin pointer is at bin 0, `done` is low and `best_phase`, `best_score` and `noise_score` read zero.
- R2: Each accepted strobe advances the bin pointer by one, and bin 99 is followed by bin 0. A strobe with `smp_bit` = 1 adds one to the bin the pointer held before the step. A strobe with `smp_bit` = 0 only moves the pointer.
- R3: A bin counter stops at 255. Further 1 samples leave it at 255.
- R4: The score at phase p is 59 times the sum of bins p..p+9, plus 34 times the sum of bins p+10..p+19, plus 8 times the sum of bins p+20..p+29. All bin addresses are taken modulo 100.
- R5: `best_phase` is the lowest phase whose score is the maximum over all 100 phases, and a later equal score does not replace an earlier one. `best_score` is that maximum.
- R6: `noise_score` is the R4 score at phase (`best_phase` + 20) mod 100.
- R7: `done` is high for exactly one cycle. It rises on the 101st rising edge after the edge that captures `eval_go`. The three results are valid from that cycle and do not change until the next `done`.
- R8: A strobe seen on the edge that captures `eval_go`, or at any time during an evaluation, changes no bin and does not move the pointer.
- R9: An `eval_go` pulse during an evaluation is ignored. The running evaluation neither restarts nor gains an extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe: one phase step |
| smp_bit | input | 1 | Sampled level, 1 = carrier off |
| eval_go | input | 1 | Start-evaluation pulse |
| done | output | 1 | One-cycle pulse: results updated |
| best_phase | output | 7 | Index of the best phase bin |
| best_score | output | 24 | Kernel score at best_phase |
| noise_score | output | 24 | Kernel score 20 bins after best_phase |

## Verification
A sample affects a bin on the very edge that takes its strobe. The evaluation results appear together with `done` 101 edges after the edge that captures `eval_go`: one edge loads the first score, one hundred edges scan, and one more edge computes the noise figure. The bench drives on falling edges and counts every rising edge from the `eval_go` capture. It samples `done` on each falling edge, so the count at which `done` first appears must be exactly 101. The outputs are compared only in that cycle and later, including a falling-edge check that `done` has dropped again one cycle after.

// File: rtl/spc_pkg.sv
package spc_pkg;

  localparam int unsigned WT_LEAD = 59;
  localparam int unsigned WT_MID  = 34;
  localparam int unsigned WT_TAIL = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_NOISE = 2'd2
  } scan_st_t;

  // a and b must both be below n
  function automatic int unsigned ring_add(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned n);
    int unsigned s;
    s = a + b;
    return (s >= n) ? (s - n) : s;
  endfunction

  // kernel weight of the k-th bin inside the window
  function automatic int unsigned seg_weight(input int unsigned k,
                                             input int unsigned win);
    if (k < win)          return WT_LEAD;
    else if (k < 2 * win) return WT_MID;
    else                  return WT_TAIL;
  endfunction

  // change of the score when the window start moves one bin later:
  // lead leaves, mid and tail bins gain weight, enter joins at the tail
  function automatic logic [31:0] step_gain(input logic [31:0] lead,
                                            input logic [31:0] mid,
                                            input logic [31:0] tail,
                                            input logic [31:0] enter);
    return (mid * (WT_LEAD - WT_MID)) + (tail * (WT_MID - WT_TAIL))
         + (enter * WT_TAIL) - (lead * WT_LEAD);
  endfunction

endpackage

// File: rtl/spc_bin_ring.sv
module spc_bin_ring #(
  parameter int NBINS = 100,
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_stb,
  input  logic                     smp_bit,
  input  logic                     freeze,
  output logic [CNT_W-1:0]         bins_o [NBINS],
  output logic [$clog2(NBINS)-1:0] ptr_o,
  output logic                     accept_o
);
  localparam int PTR_W = $clog2(NBINS);

  logic [CNT_W-1:0] bins_q [NBINS];
  logic [PTR_W-1:0] ptr_q;
  logic             at_top;

  assign accept_o = smp_stb & ~freeze;
  assign at_top   = (bins_q[ptr_q] == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBINS; i++) bins_q[i] <= '0;
      ptr_q <= '0;
    end else if (accept_o) begin
      if (smp_bit && !at_top) bins_q[ptr_q] <= bins_q[ptr_q] + 1'b1;
      ptr_q <= (ptr_q == PTR_W'(NBINS - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assign bins_o = bins_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/spc_scan_engine.sv
module spc_scan_engine
  import spc_pkg::*;
#(
  parameter int NBINS = 100,
  parameter int CNT_W = 8,
  parameter int ACC_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [CNT_W-1:0]         bins_i [NBINS],
  output logic                     busy_o,
  output logic                     scan_on_o,
  output logic                     done_o,
  output logic [$clog2(NBINS)-1:0] idx_o,
  output logic [ACC_W-1:0]         run_max_o,
  output logic [$clog2(NBINS)-1:0] best_o,
  output logic [ACC_W-1:0]         score_o,
  output logic [ACC_W-1:0]         noise_o
);
  localparam int IDX_W = $clog2(NBINS);
  localparam int WIN   = NBINS / 10;

  scan_st_t         st_q;
  logic [IDX_W-1:0] idx_q, best_q, res_best_q;
  logic [ACC_W-1:0] acc_q, max_q, res_score_q, res_noise_q;
  logic             done_q;
  logic [31:0]      lead_c, mid_c, tail_c, enter_c;
  logic [ACC_W-1:0] acc_step;
  logic             better;

  // full kernel sum at a given start phase
  function automatic logic [31:0] kernel_at(input int unsigned base);
    logic [31:0] s;
    s = '0;
    for (int unsigned k = 0; k < 3 * WIN; k++)
      s += 32'(seg_weight(k, WIN)) * 32'(bins_i[ring_add(base, k, NBINS)]);
    return s;
  endfunction

  always_comb begin
    lead_c  = 32'(bins_i[idx_q]);
    mid_c   = 32'(bins_i[ring_add(32'(idx_q), WIN,     NBINS)]);
    tail_c  = 32'(bins_i[ring_add(32'(idx_q), 2 * WIN, NBINS)]);
    enter_c = 32'(bins_i[ring_add(32'(idx_q), 3 * WIN, NBINS)]);
    acc_step = ACC_W'(32'(acc_q) + step_gain(lead_c, mid_c, tail_c, enter_c));
    better   = (acc_q > max_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      best_q      <= '0;
      acc_q       <= '0;
      max_q       <= '0;
      res_best_q  <= '0;
      res_score_q <= '0;
      res_noise_q <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (go) begin
            acc_q  <= ACC_W'(kernel_at(0));
            idx_q  <= '0;
            max_q  <= '0;
            best_q <= '0;
            st_q   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (better) begin
            max_q  <= acc_q;
            best_q <= idx_q;
          end
          acc_q <= acc_step;
          if (idx_q == IDX_W'(NBINS - 1)) st_q  <= ST_NOISE;
          else                            idx_q <= idx_q + 1'b1;
        end
        ST_NOISE: begin
          res_best_q  <= best_q;
          res_score_q <= max_q;
          res_noise_q <= ACC_W'(kernel_at(ring_add(32'(best_q), 2 * WIN, NBINS)));
          done_q      <= 1'b1;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign scan_on_o = (st_q == ST_SCAN);
  assign done_o    = done_q;
  assign idx_o     = idx_q;
  assign run_max_o = max_q;
  assign best_o    = res_best_q;
  assign score_o   = res_score_q;
  assign noise_o   = res_noise_q;
endmodule

// File: rtl/sec_phase_corr.sv
module sec_phase_corr #(
  parameter int NBINS = 100,
  parameter int CNT_W = 8,
  parameter int ACC_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_stb,
  input  logic                     smp_bit,
  input  logic                     eval_go,
  output logic                     done,
  output logic [$clog2(NBINS)-1:0] best_phase,
  output logic [ACC_W-1:0]         best_score,
  output logic [ACC_W-1:0]         noise_score
);
  localparam int IDX_W = $clog2(NBINS);

  logic [CNT_W-1:0] bins_w [NBINS];
  logic [IDX_W-1:0] ring_ptr;
  logic             ring_accept;
  logic             eng_busy;
  logic             eng_scan;
  logic [IDX_W-1:0] eng_idx;
  logic [ACC_W-1:0] eng_max;
  logic             ring_freeze;

  assign ring_freeze = eng_busy | eval_go;

  spc_bin_ring #(.NBINS(NBINS), .CNT_W(CNT_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .smp_bit  (smp_bit),
    .freeze   (ring_freeze),
    .bins_o   (bins_w),
    .ptr_o    (ring_ptr),
    .accept_o (ring_accept)
  );

  spc_scan_engine #(.NBINS(NBINS), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (eval_go),
    .bins_i    (bins_w),
    .busy_o    (eng_busy),
    .scan_on_o (eng_scan),
    .done_o    (done),
    .idx_o     (eng_idx),
    .run_max_o (eng_max),
    .best_o    (best_phase),
    .score_o   (best_score),
    .noise_o   (noise_score)
  );
endmodule

// File: rtl/spc_chk.sv
module spc_chk #(
  parameter int NBINS = 100,
  parameter int ACC_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     eval_go,
  input logic                     done,
  input logic                     busy,
  input logic                     scan_on,
  input logic [$clog2(NBINS)-1:0] scan_idx,
  input logic [ACC_W-1:0]         run_max,
  input logic                     accept,
  input logic [$clog2(NBINS)-1:0] ring_ptr,
  input logic [$clog2(NBINS)-1:0] best_phase
);
  localparam int IDX_W = $clog2(NBINS);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7

  AST_RING_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ring_ptr)); // R8

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ring_ptr == (($past(ring_ptr) == IDX_W'(NBINS - 1)) ? '0 : $past(ring_ptr) + 1'b1)); // R2

  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_on && eval_go && scan_idx != IDX_W'(NBINS - 1)) |=> (scan_on && scan_idx == $past(scan_idx) + 1'b1)); // R9

  AST_MAX_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_on |=> run_max >= $past(run_max)); // R5

  AST_BEST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> best_phase < IDX_W'(NBINS)); // R5
endmodule

bind sec_phase_corr spc_chk #(.NBINS(NBINS), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eval_go    (eval_go),
  .done       (done),
  .busy       (eng_busy),
  .scan_on    (eng_scan),
  .scan_idx   (eng_idx),
  .run_max    (eng_max),
  .accept     (ring_accept),
  .ring_ptr   (ring_ptr),
  .best_phase (best_phase)
);

// File: tb/sec_phase_corr_bench.sv
`timescale 1ns/1ps
module sec_phase_corr_bench;
  localparam int NB = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_stb = 1'b0;
  logic        smp_bit = 1'b0;
  logic        eval_go = 1'b0;
  logic        done;
  logic [6:0]  best_phase;
  logic [23:0] best_score;
  logic [23:0] noise_score;

  int total = 0;
  int bad = 0;
  int cyc_cnt = 0;
  bit finished = 0;

  int m_cnt [NB];
  int m_ptr;

  // seconds, block start, block length, expected best phase
  localparam int VEC [4][4] = '{
    '{1, 20, 10, 20},
    '{2, 95, 10, 95},
    '{3, 40, 20, 40},
    '{1,  0, 100, 0}
  };

  sec_phase_corr u_sec_phase_corr (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_bit(smp_bit),
    .eval_go(eval_go), .done(done), .best_phase(best_phase),
    .best_score(best_score), .noise_score(noise_score)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 190000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog R7 actual=hung expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int model_score(input int base);
    int s = 0;
    for (int k = 0; k < 30; k++) begin
      int w = (k < 10) ? 59 : ((k < 20) ? 34 : 8);
      s += w * m_cnt[(base + k) % NB];
    end
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_stb = 1'b0; eval_go = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NB; i++) m_cnt[i] = 0;
    m_ptr = 0;
  endtask

  task automatic drive_sample(input logic b);
    @(negedge clk);
    smp_stb = 1'b1;
    smp_bit = b;
    if (b && m_cnt[m_ptr] < 255) m_cnt[m_ptr]++;
    m_ptr = (m_ptr + 1) % NB;
  endtask

  task automatic end_samples();
    @(negedge clk);
    smp_stb = 1'b0;
    smp_bit = 1'b0;
  endtask

  task automatic feed(input int secs, input int st, input int len);
    for (int s = 0; s < secs; s++)
      for (int i = 0; i < NB; i++)
        drive_sample(((i - st + NB) % NB) < len);
    end_samples();
  endtask

  // junk: strobe 1s every cycle and pulse eval_go again mid-scan
  task automatic run_eval(input bit junk, output int cyc);
    cyc = -1;
    @(negedge clk);
    eval_go = 1'b1;
    @(negedge clk);
    eval_go = 1'b0;
    for (int n = 1; n <= 300; n++) begin
      @(negedge clk);
      if (done) begin
        cyc = n;
        smp_stb = 1'b0;
        eval_go = 1'b0;
        break;
      end
      if (junk) begin
        smp_stb = 1'b1;
        smp_bit = 1'b1;
        eval_go = (n == 50);
      end
    end
    smp_stb = 1'b0;
    eval_go = 1'b0;
  endtask

  task automatic check_results(input string tag);
    int best = 0;
    int mx = model_score(0);
    for (int p = 1; p < NB; p++) begin
      int sc = model_score(p);
      if (sc > mx) begin mx = sc; best = p; end
    end
    chk({tag, " R5 best_phase"}, int'(best_phase), best);
    chk({tag, " R4 best_score"}, int'(best_score), mx);
    chk({tag, " R6 noise_score"}, int'(noise_score), model_score((best + 20) % NB));
  endtask

  initial begin
    int cyc;
    int held_best, held_score;

    // R1: reset state
    do_reset();
    chk("R1 done low", int'(done), 0);
    chk("R1 best_phase", int'(best_phase), 0);
    chk("R1 best_score", int'(best_score), 0);
    chk("R1 noise_score", int'(noise_score), 0);
    run_eval(0, cyc);
    chk("R7 latency empty", cyc, 101);
    chk("R1 empty bins score", int'(best_score), 0);
    chk("R1 empty bins noise", int'(noise_score), 0);

    // vector table: R4 R5 R6 R7
    for (int v = 0; v < 4; v++) begin
      do_reset();
      feed(VEC[v][0], VEC[v][1], VEC[v][2]);
      run_eval(0, cyc);
      chk("R7 latency", cyc, 101);
      chk("R5 table best", int'(best_phase), VEC[v][3]);
      check_results("vec");
      @(negedge clk);
      chk("R7 done one cycle", int'(done), 0);
    end

    // R2: pointer wraps after 99; only 1 samples count
    do_reset();
    for (int i = 0; i < 130; i++)
      drive_sample((i == 3) || (i >= 100 && i <= 104));
    end_samples();
    run_eval(0, cyc);
    chk("R2 wrap latency", cyc, 101);
    chk("R2 wrap best", int'(best_phase), 0);
    chk("R2 wrap score", int'(best_score), 59 * 6);
    check_results("R2");

    // R3: saturation at 255
    do_reset();
    feed(300, 0, 100);
    run_eval(0, cyc);
    chk("R3 saturated score", int'(best_score), 255 * 10 * 101);
    chk("R3 saturated noise", int'(noise_score), 255 * 10 * 101);
    chk("R5 tie keeps first", int'(best_phase), 0);

    // R8 / R9: strobes and a second go during the scan
    do_reset();
    feed(1, 30, 10);
    run_eval(1, cyc);
    chk("R9 no restart latency", cyc, 101);
    check_results("R8 during scan");
    held_best = int'(best_phase);
    held_score = int'(best_score);
    for (int n = 0; n < 120; n++) begin
      @(negedge clk);
      if (done) chk("R9 extra done", 1, 0);
    end
    // R7: results held while new samples arrive
    feed(2, 60, 10);
    chk("R7 held best", int'(best_phase), held_best);
    chk("R7 held score", int'(best_score), held_score);
    run_eval(0, cyc);
    chk("R8 pointer untouched best", int'(best_phase), 60);
    check_results("R8 after scan");

    // R8: strobe on the same edge as eval_go is dropped
    do_reset();
    feed(1, 10, 10);
    @(negedge clk);
    eval_go = 1'b1; smp_stb = 1'b1; smp_bit = 1'b1;
    @(negedge clk);
    eval_go = 1'b0; smp_stb = 1'b0; smp_bit = 1'b0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (done) break;
    end
    run_eval(0, cyc);
    chk("R8 go-edge strobe", int'(best_score), 590);
    check_results("R8 go edge");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule